// File: doc/BRIEF.md
# Endian-Selectable Load Assembler

This block sits between a processor core and a byte-addressed memory whose read port returns one 32-bit word per access. The memory accepts only addresses that are multiples of four and returns the data one cycle after the read is issued. The core asks for a byte, a halfword or a word at any byte address. The block fetches the word or words that hold those bytes and puts them together in either byte order. It returns the value zero-extended to 32 bits.

The byte order comes from a mode input that the core may change from one request to the next. The block samples the mode together with the address and size when it accepts a request, and keeps using that mode for every memory read the request needs. A value that lies inside one aligned word is returned one cycle after acceptance, and requests can follow each other every cycle. A value that reaches past the end of an aligned word needs two reads: first the word that holds its starting address, then the next aligned word. In that case the block pauses the core for one cycle and returns the merged value two cycles after acceptance.

Top module: `endian_load_unit`

## Requirements
- R1: While reset is held and in the first cycle after reset, rsp_valid and mem_rd_en are low and req_ready is high.
- R2: Bits 8k+7..8k of mem_rdata carry the byte at address (word address + k). Every read has mem_addr[1:0] equal to 0.
- R3: When req_big is 0 at acceptance, the byte at the request address lands in rsp_data[7:0] and each following address fills the next higher byte.
- R4: When req_big is 1 at acceptance, the byte at the request address lands in the most significant byte of the value (for example, bytes 12,34,56,78 at rising addresses read as 0x12345678).
- R5: req_size encodes 00 as byte, 01 as halfword, and 10 or 11 as word. Result bits above the access width are 0.
- R6: A request accepted at offset o with o plus width at most 4 issues one read in the cycle of acceptance. rsp_valid is high in the next cycle and req_ready stays high, so accepts can follow every cycle.
- R7: A request whose bytes run past the end of its aligned word reads the word that holds its address in the cycle of acceptance and the next aligned word in the following cycle. req_ready is low in that following cycle, and rsp_valid is high two cycles after acceptance.
- R8: A change of req_big after a request is accepted does not alter that request's result.
- R9: The second read of a split request goes to the next aligned word address modulo 2^AW, so a value at the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| req_valid | input | 1 | Core presents a load request |
| req_addr | input | AW | Byte address of the load |
| req_size | input | 2 | Access width: 00 byte, 01 halfword, 1x word |
| req_big | input | 1 | Byte order for this request: 1 big-endian, 0 little-endian |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | rsp_data holds a finished load result |
| rsp_data | output | 32 | Assembled value, zero-extended |
| mem_rd_en | output | 1 | Read strobe to memory |
| mem_addr | output | AW | Word-aligned read address |
| mem_rdata | input | 32 | Read data, valid one cycle after the strobe |

## Verification
If the request is stored incorrectly, wrong data shows up on rsp_data in the same response. This includes an offset, size or mode value that is captured wrong, or one that changes while a split load is still pending. The bench checks every combination of offset, size and mode against a byte pattern computed from the address. A stuck or mis-sequenced controller shows up within one or two cycles of an accept: a response arrives too early or too late, req_ready fails to drop for exactly one cycle, or the second read goes to the wrong word. The wrap-around case catches a carry out of the top of the address that is lost or handled wrong.

// File: rtl/elu_pkg.sv
package elu_pkg;
  localparam int WBYTES = 4;
  localparam int WBITS  = 8 * WBYTES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ONE,
    ST_FETCH2,
    ST_MERGE
  } phase_e;

  function automatic logic [2:0] span_of(logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/elu_addr.sv
module elu_addr #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic [AW-1:0] word_addr,
  output logic [AW-1:0] next_word_addr,
  output logic [1:0]    offset,
  output logic          crosses
);
  import elu_pkg::*;

  logic [3:0] end_pos;

  always_comb begin
    offset         = addr[1:0];
    word_addr      = {addr[AW-1:2], 2'b00};
    next_word_addr = {addr[AW-1:2] + 1'b1, 2'b00};
    end_pos        = {2'b00, addr[1:0]} + {1'b0, span_of(size)};
    crosses        = end_pos > 4'd4;
  end
endmodule

// File: rtl/elu_ctrl.sv
module elu_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            crosses,
  output logic            req_ready,
  output logic            accept,
  output elu_pkg::phase_e phase
);
  import elu_pkg::*;

  phase_e phase_q, phase_d;

  always_comb begin
    req_ready = (phase_q != ST_FETCH2);
    accept    = req_valid & req_ready;
    phase_d   = phase_q;
    case (phase_q)
      ST_FETCH2: phase_d = ST_MERGE;
      default: begin
        if (accept) phase_d = crosses ? ST_FETCH2 : ST_ONE;
        else        phase_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= ST_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/elu_merge.sv
module elu_merge (
  input  logic [31:0] lo_word,
  input  logic [31:0] hi_word,
  input  logic        use_pair,
  input  logic [1:0]  offset,
  input  logic [1:0]  size,
  input  logic        big,
  output logic [31:0] value
);
  import elu_pkg::*;

  localparam int WIN = 2 * WBYTES;

  logic [7:0] window [WIN];
  logic [2:0] n;

  assign n = span_of(size);

  always_comb begin
    for (int k = 0; k < WBYTES; k++) begin
      window[k]          = use_pair ? lo_word[8*k +: 8] : hi_word[8*k +: 8];
      window[k + WBYTES] = use_pair ? hi_word[8*k +: 8] : 8'h00;
    end
  end

  for (genvar i = 0; i < WBYTES; i++) begin : g_lane
    logic [2:0] pick;
    always_comb begin
      if (big) pick = {1'b0, offset} + (n - 3'd1 - 3'(i));
      else     pick = {1'b0, offset} + 3'(i);
      value[8*i +: 8] = (3'(i) < n) ? window[pick] : 8'h00;
    end
  end
endmodule

// File: rtl/endian_load_unit.sv
module endian_load_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_big,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata
);
  import elu_pkg::*;

  logic [AW-1:0] word_addr, next_word_addr;
  logic [1:0]    offset;
  logic          crosses, accept;
  phase_e        phase;

  logic [AW-1:0] nxt_q;
  logic [1:0]    off_q, sz_q;
  logic          big_q;
  logic [31:0]   lo_q;
  logic          hold_en, lo_en;

  elu_addr #(.AW(AW)) u_addr (
    .addr           (req_addr),
    .size           (req_size),
    .word_addr      (word_addr),
    .next_word_addr (next_word_addr),
    .offset         (offset),
    .crosses        (crosses)
  );

  elu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .crosses   (crosses),
    .req_ready (req_ready),
    .accept    (accept),
    .phase     (phase)
  );

  assign hold_en = accept;
  assign lo_en   = (phase == ST_FETCH2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q <= '0;
      off_q <= '0;
      sz_q  <= '0;
      big_q <= 1'b0;
    end else if (hold_en) begin
      nxt_q <= next_word_addr;
      off_q <= offset;
      sz_q  <= req_size;
      big_q <= req_big;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= mem_rdata;
  end

  assign mem_rd_en = accept | lo_en;
  assign mem_addr  = lo_en ? nxt_q : word_addr;
  assign rsp_valid = (phase == ST_ONE) | (phase == ST_MERGE);

  elu_merge u_merge (
    .lo_word  (lo_q),
    .hi_word  (mem_rdata),
    .use_pair (phase == ST_MERGE),
    .offset   (off_q),
    .size     (sz_q),
    .big      (big_q),
    .value    (rsp_data)
  );
endmodule

// File: rtl/elu_chk.sv
module elu_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [31:0]   rsp_data,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr
);
  logic       acc;
  logic [3:0] reach;
  logic       split;

  assign acc   = req_valid & req_ready;
  assign reach = {2'b00, req_addr[1:0]} + ((req_size == 2'b00) ? 4'd1 :
                 (req_size == 2'b01) ? 4'd2 : 4'd4);
  assign split = reach > 4'd4;

  // R2
  aligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr[1:0] == 2'b00));

  // R6
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !split) |=> (rsp_valid && req_ready));

  // R7
  split_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && split) |=> (!req_ready && !rsp_valid && mem_rd_en));

  // R7
  split_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && split) |=> ##1 rsp_valid);

  // R9
  second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && split) |=> (mem_addr == {$past(req_addr[AW-1:2]) + 1'b1, 2'b00}));

  // R5
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_size == 2'b00) |=> (rsp_data[31:8] == 24'h0));

  // R6
  read_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> mem_rd_en);
endmodule

bind endian_load_unit elu_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .mem_rd_en (mem_rd_en),
  .mem_addr  (mem_addr)
);

// File: tb/sim_endian_load_unit.sv
`timescale 1ns/1ps
module sim_endian_load_unit;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          req_big;
  logic          req_ready;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [31:0] q_data [$];
  int          q_cyc  [$];

  always #2 clk = ~clk;

  endian_load_unit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_big(req_big), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mbyte(int a);
    int m;
    m = a & 32'hFFFF;
    return 8'((m * 29) + ((m >> 8) * 7) + 5);
  endfunction

  // R2: lane k of a word carries the byte at word address + k
  function automatic logic [31:0] mword(logic [AW-1:0] wa);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = mbyte(int'(wa) + k);
    return w;
  endfunction

  function automatic logic [31:0] expect_val(logic [AW-1:0] a, logic [1:0] sz, logic big);
    int n;
    logic [31:0] v;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    v = '0;
    for (int i = 0; i < n; i++) begin
      if (big) v[8*(n-1-i) +: 8] = mbyte(int'(a) + i);
      else     v[8*i +: 8]       = mbyte(int'(a) + i);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rdata <= mword(mem_addr);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_rd_en) begin
      checks++;
      if (mem_addr[1:0] != 2'b00) begin
        fails++;
        $display("FAIL R2 unaligned read addr=%h expected low bits 00", mem_addr);
      end
    end
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_data.size() == 0) begin
        fails++;
        $display("FAIL R6/R7 response with none pending data=%h expected none", rsp_data);
      end else begin
        logic [31:0] ed;
        int ec;
        ed = q_data.pop_front();
        ec = q_cyc.pop_front();
        if (rsp_data !== ed) begin
          fails++;
          $display("FAIL R3/R4/R5/R8/R9 data=%h expected %h", rsp_data, ed);
        end
        if (cyc != ec) begin
          fails++;
          $display("FAIL R6/R7 response cycle=%0d expected %0d", cyc, ec);
        end
      end
    end
  end

  task automatic send(input logic [AW-1:0] a, input logic [1:0] sz, input logic big,
                      input bit flip_after);
    int fin;
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = sz;
    req_big   = big;
    while (!req_ready) @(negedge clk);
    fin = ({2'b00, a[1:0]} + ((sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4)) > 4 ? 2 : 1;
    q_data.push_back(expect_val(a, sz, big));
    q_cyc.push_back(cyc + fin);
    @(negedge clk);
    req_valid = 1'b0;
    // R8: mode changes after acceptance must not affect the pending result
    if (flip_after) req_big = ~big;
  endtask

  task automatic check_stall();
    // R7: one cycle after a split accept, ready is low
    checks++;
    if (req_ready !== 1'b0) begin
      fails++;
      $display("FAIL R7 req_ready=%b expected 0", req_ready);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired after 20000 cycles, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_size  = 2'b00;
    req_big   = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    checks++;
    if (rsp_valid !== 1'b0 || mem_rd_en !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset rsp_valid=%b rd=%b ready=%b expected 0 0 1",
               rsp_valid, mem_rd_en, req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after reset
    checks++;
    if (rsp_valid !== 1'b0 || mem_rd_en !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 post-reset rsp_valid=%b rd=%b ready=%b expected 0 0 1",
               rsp_valid, mem_rd_en, req_ready);
    end

    // R3 R4 R5 R6 R7: every offset, size and mode, back to back
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          send(AW'(16'h0100 + o), 2'(s), b[0], 1'b0);
    repeat (4) @(negedge clk);

    // R7 stall observed directly: word at offset 2 is split
    req_valid = 1'b1; req_addr = 16'h0232; req_size = 2'b10; req_big = 1'b1;
    q_data.push_back(expect_val(16'h0232, 2'b10, 1'b1));
    q_cyc.push_back(cyc + 2);
    @(negedge clk);
    req_valid = 1'b0;
    check_stall();
    repeat (3) @(negedge clk);

    // R8: flip mode right after split and single accepts
    send(16'h0413, 2'b01, 1'b1, 1'b1);
    send(16'h0421, 2'b10, 1'b0, 1'b1);
    send(16'h0440, 2'b10, 1'b1, 1'b1);
    repeat (4) @(negedge clk);

    // R9: wrap at the top of the address space
    send(16'hFFFF, 2'b10, 1'b0, 1'b0);
    send(16'hFFFE, 2'b11, 1'b1, 1'b0);
    send(16'hFFFF, 2'b01, 1'b1, 1'b0);
    send(16'hFFFC, 2'b10, 1'b0, 1'b0);
    repeat (6) @(negedge clk);

    // all responses arrived
    checks++;
    if (q_data.size() != 0) begin
      fails++;
      $display("FAIL R6/R7 pending responses=%0d expected 0", q_data.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule